// File: doc/BRIEF.md
# Lossy-Operation Safety Cutout Supervisor

This block guards a phase-control dimmer against a load that runs in a lossy state, such as an idling transformer. It does not detect the faults itself. It receives two event strobes, one for a high saturation current (conduction beyond 180°) and one for a retrigger. It weighs how often these events arrive against the passage of line half-waves. A small saturating up/down score rises by one for every event. The score leaks down by one step on every fifteenth half-wave. When the score reaches its trip level, the block requests a safety cutout.

The score and the half-wave prescaler return to zero while the dimmer is OFF and on any cycle that flags a short line outage. Once raised, the cutout request stays up until the OFF state is entered, and a short outage alone does not drop it. All pins are plain level or strobe signals sampled on the rising clock edge. No data stream flows through the block, so no valid/ready handshake or back-pressure applies.

Top module: `lossy_cutout_supervisor`

## Requirements
- R1: During and right after reset, `evt_score` is 0 and `cutout_req` is 0.
- R2: With no clear and no leak step, each cycle raises `evt_score` by the number of event strobes high in that cycle: one for `sat_evt`, one for `retrig_evt`, and two when both are high. The new value is visible after that rising edge.
- R3: `halfwave_tick` pulses are counted modulo 15. The 15th pulse after reset or after the last clear is a leak step, and so is every 15th pulse after that. A leak step lowers the score by one only if the score is nonzero, and the prescaler wraps in either case.
- R4: When a leak step and event strobes land on the same edge, the score changes by the number of events minus one. A single event together with a leak step leaves a nonzero score unchanged.
- R5: The score saturates at 15 and never wraps, and it never goes below 0.
- R6: `cutout_req` is 1 in every cycle in which `evt_score` is 15 (the trip level).
- R7: Once `cutout_req` is 1, it stays 1 until `dimmer_off` is sampled high. This holds even when `outage_det` has cleared the score.
- R8: When `dimmer_off` or `outage_det` is sampled high, the score is 0 after that edge and the prescaler restarts. A tick in the same cycle is not counted, so the next leak step needs 15 further ticks.
- R9: When `dimmer_off` is sampled high, `cutout_req` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sat_evt | input | 1 | One-cycle strobe: high saturation current seen |
| retrig_evt | input | 1 | One-cycle strobe: retrigger was issued |
| halfwave_tick | input | 1 | One-cycle strobe per line half-wave |
| dimmer_off | input | 1 | Level: dimmer is in the OFF state |
| outage_det | input | 1 | Strobe: short line outage detected |
| cutout_req | output | 1 | Safety cutout request |
| evt_score | output | 4 | Current up/down score, for observation |

## Verification
The assertions assume that every input is a clean synchronous level or strobe, sampled once per rising edge, and that reset is applied before the first meaningful edge. They also assume that two event strobes in one cycle are meant to count as two events. The stimulus drives every input half a period away from the active edge and starts with reset held low. It mixes directed sequences (saturation pumping, long leak runs, clears in the middle of the prescaler) with a pseudo-random sweep over all 32 input combinations. The bench keeps a cycle-accurate arithmetic model of score, prescaler and latch, built from the requirements alone.

// File: rtl/cutout_pkg.sv
`timescale 1ns/1ps
package cutout_pkg;
  localparam int SCORE_W    = 4;
  localparam int TRIP_LEVEL = 15;
  localparam int LEAK_EVERY = 15;
  localparam int N_SOURCES  = 2;

  function automatic int unsigned width_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/halfwave_prescaler.sv
`timescale 1ns/1ps
module halfwave_prescaler #(
  parameter int PERIOD = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic leak
);
  localparam int PW = cutout_pkg::width_for(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase_q;

  assign leak = tick && !restart && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (tick)     phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assert_leak_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    leak |-> tick);
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));
  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
endmodule

// File: rtl/score_counter.sv
`timescale 1ns/1ps
module score_counter #(
  parameter int W     = 4,
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [N_EVT-1:0] evt,
  input  logic             leak,
  output logic [W-1:0]     score
);
  localparam int SW = W + cutout_pkg::width_for(N_EVT + 1) + 1;
  localparam logic [SW-1:0] MAXV = SW'((1 << W) - 1);

  logic [SW-1:0] ups;
  logic [SW-1:0] sum;
  logic          dn;
  logic [W-1:0]  score_q;

  always_comb begin
    ups = '0;
    for (int i = 0; i < N_EVT; i++) ups = ups + SW'(evt[i]);
  end

  assign dn  = leak && (score_q != '0);
  assign sum = SW'(score_q) + ups - SW'(dn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     score_q <= '0;
    else if (clear) score_q <= '0;
    else            score_q <= (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
  end

  assign score = score_q;

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (score == '0));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && score == MAXV[W-1:0] && !leak) |=> (score == MAXV[W-1:0]));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && score == '0 && evt == '0) |=> (score == '0));
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && leak && $countones(evt) == 1 && score != '0 && score != MAXV[W-1:0])
      |=> $stable(score));
endmodule

// File: rtl/trip_latch.sv
`timescale 1ns/1ps
module trip_latch #(
  parameter int W    = 4,
  parameter int TRIP = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         off,
  input  logic [W-1:0] score,
  output logic         trip
);
  localparam logic [W-1:0] LVL = W'(TRIP);

  logic hit;
  logic held_q;

  assign hit = (score >= LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= 1'b0;
    else if (off) held_q <= 1'b0;
    else          held_q <= held_q | hit;
  end

  assign trip = held_q | hit;

  assert_trip_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !off) |=> trip);
  assert_off_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !held_q);
endmodule

// File: rtl/lossy_cutout_supervisor.sv
`timescale 1ns/1ps
module lossy_cutout_supervisor #(
  parameter int SCORE_W    = cutout_pkg::SCORE_W,
  parameter int TRIP_LEVEL = cutout_pkg::TRIP_LEVEL,
  parameter int LEAK_EVERY = cutout_pkg::LEAK_EVERY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sat_evt,
  input  logic               retrig_evt,
  input  logic               halfwave_tick,
  input  logic               dimmer_off,
  input  logic               outage_det,
  output logic               cutout_req,
  output logic [SCORE_W-1:0] evt_score
);
  localparam int NSRC = cutout_pkg::N_SOURCES;

  logic            wipe;
  logic            leak_step;
  logic [NSRC-1:0] events;

  assign wipe   = dimmer_off | outage_det;
  assign events = {retrig_evt, sat_evt};

  halfwave_prescaler #(.PERIOD(LEAK_EVERY)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(wipe), .tick(halfwave_tick), .leak(leak_step)
  );

  score_counter #(.W(SCORE_W), .N_EVT(NSRC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(wipe), .evt(events), .leak(leak_step), .score(evt_score)
  );

  trip_latch #(.W(SCORE_W), .TRIP(TRIP_LEVEL)) u_trip (
    .clk(clk), .rst_n(rst_n), .off(dimmer_off), .score(evt_score), .trip(cutout_req)
  );

  assert_trip_at_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_score == SCORE_W'(TRIP_LEVEL)) |-> cutout_req);
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dimmer_off |=> (!cutout_req && evt_score == '0));
endmodule

// File: tb/sim_lossy_cutout_supervisor.sv
`timescale 1ns/1ps
module sim_lossy_cutout_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sat_evt = 0, retrig_evt = 0, halfwave_tick = 0, dimmer_off = 0, outage_det = 0;
  logic cutout_req;
  logic [3:0] evt_score;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_cnt = 0, m_pre = 0;
  bit m_held = 0;

  always #2 clk = ~clk;

  lossy_cutout_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .sat_evt(sat_evt), .retrig_evt(retrig_evt),
    .halfwave_tick(halfwave_tick), .dimmer_off(dimmer_off), .outage_det(outage_det),
    .cutout_req(cutout_req), .evt_score(evt_score)
  );

  function automatic bit m_trip();
    return m_held || (m_cnt >= 15);
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit s, input bit r, input bit t, input bit off, input bit out);
    int dn = 0;
    int n;
    m_held = off ? 1'b0 : (m_held || (m_cnt >= 15));
    if (off || out) begin
      m_cnt = 0; m_pre = 0;
    end else begin
      if (t) begin
        if (m_pre == 14) begin m_pre = 0; dn = (m_cnt != 0) ? 1 : 0; end
        else m_pre++;
      end
      n = m_cnt + int'(s) + int'(r) - dn;
      m_cnt = (n > 15) ? 15 : n;
    end
  endtask

  task automatic step(input string req, input bit s, input bit r, input bit t, input bit off, input bit out);
    @(negedge clk);
    sat_evt = s; retrig_evt = r; halfwave_tick = t; dimmer_off = off; outage_det = out;
    @(posedge clk);
    model_edge(s, r, t, off, out);
    #1;
    check(req, int'(evt_score), m_cnt, "score");
    check(req, int'(cutout_req), int'(m_trip()), "cutout");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(evt_score), 0, "score in reset");
    check("R1", int'(cutout_req), 0, "cutout in reset");
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);

    // R2: single and double events
    step("R2", 1, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 0, 0);
    step("R2", 1, 1, 0, 0, 0);
    check("R2", int'(evt_score), 4, "score after 1+1+2");

    // R3: 15 ticks give one leak step
    for (int i = 0; i < 14; i++) step("R3", 0, 0, 1, 0, 0);
    check("R3", int'(evt_score), 4, "no leak before 15th tick");
    step("R3", 0, 0, 1, 0, 0);
    check("R3", int'(evt_score), 3, "leak on 15th tick");
    for (int i = 0; i < 45; i++) step("R3", 0, 0, 1, 0, 0);
    check("R3", int'(evt_score), 0, "three leaks to zero");
    for (int i = 0; i < 30; i++) step("R5", 0, 0, 1, 0, 0);
    check("R5", int'(evt_score), 0, "no underflow");

    // R4: event with leak step
    step("R4", 1, 0, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) step("R4", 0, 0, 1, 0, 0);
    step("R4", 1, 0, 1, 0, 0);
    check("R4", int'(evt_score), 2, "event+leak unchanged");

    // R5/R6: saturation and trip
    for (int i = 0; i < 12; i++) step("R5", 1, 1, 0, 0, 0);
    check("R5", int'(evt_score), 15, "saturated");
    check("R6", int'(cutout_req), 1, "trip at 15");

    // R7: outage clears score, trip held
    step("R7", 0, 0, 0, 0, 1);
    check("R7", int'(evt_score), 0, "outage clears");
    check("R7", int'(cutout_req), 1, "trip held after outage");
    for (int i = 0; i < 20; i++) step("R7", 0, 0, 1, 0, 0);
    check("R7", int'(cutout_req), 1, "trip still held");

    // R9: off drops trip
    step("R9", 0, 0, 0, 1, 0);
    check("R9", int'(cutout_req), 0, "off clears trip");
    step("R9", 1, 1, 1, 1, 0);
    check("R9", int'(evt_score), 0, "events ignored while off");

    // R8: prescaler restart
    step("R8", 1, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R8", 0, 0, 1, 0, 0);
    step("R8", 1, 1, 1, 0, 1);
    step("R8", 1, 1, 0, 0, 0);
    for (int i = 0; i < 14; i++) step("R8", 0, 0, 1, 0, 0);
    check("R8", int'(evt_score), 2, "no leak 14 ticks after clear");
    step("R8", 0, 0, 1, 0, 0);
    check("R8", int'(evt_score), 1, "leak at 15th tick after clear");

    // mixed sweep, clears kept rare
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R2", lf[0] & lf[3], lf[1] & lf[5], lf[2] | lf[7],
           (lf[15:10] == 6'd0), (lf[15:10] == 6'd1));
    end
    for (int c = 0; c < 32; c++) step("R4", c[0], c[1], c[2], c[3], c[4]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule